// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block turns single read or write requests from the chip's internal side into timed cycles on a multiplexed address/data bus. For each request it drives the address, pulses an active-high address latch strobe, and then either asserts the active-low read strobe and captures the returned data, or drives write data and pulses the write strobes. It also generates a clock output at half the core clock. Every bus cycle lasts three periods of that clock output.

Two configuration bits and a live width input set the data bus to 8 or 16 bits. A third configuration bit selects the role of one output pin. It is either an active-low high-byte enable that is held for the whole cycle, or an active-low high-byte write strobe. On an 8-bit bus a word request becomes two byte cycles. The requester uses a busy/done handshake and gets read data with the done pulse.

Top module: `ext_bus_seq`

## Requirements
- R1: `ale` is high only while `busy` is high. It is high for exactly the first clock-output period (2 clock cycles) of every bus cycle, and during that time `ad_oe`=1 and `ad_out` carries the cycle's address.
- R2: A bus cycle is three clock-output periods (6 clock cycles). `rd_n` (reads) and the write strobes (writes) are low only in the second period, for 2 cycles, and every strobe is high in the third period.
- R3: Bus width comes from (`cfg_bw_a`,`cfg_bw_b`): (0,0) and (0,1) give 8 bits, (1,0) gives 16 bits, and (1,1) gives 16 bits when `bus_wide_in`=1 and 8 bits when it is 0. The width is taken when a request is accepted.
- R4: When the width is fixed by (`cfg_bw_a`,`cfg_bw_b`), `bus_wide_in` has no effect on the cycles produced.
- R5: On a 16-bit bus with `cfg_hi_enable`=1, `hi_n` is low for the whole cycle exactly when the high byte is touched. The lanes are encoded as `hi_n`=0 with A0=0 for both bytes, `hi_n`=0 with A0=1 for the high byte only, and `hi_n`=1 with A0=0 for the low byte only. A word request to an odd address is issued at the even address below it.
- R6: On a 16-bit bus with `cfg_hi_enable`=0, `hi_n` is a high-byte write strobe and pulses only on writes that touch the high byte. `wr_n` pulses only on writes that touch the low byte. Reads leave both high.
- R7: With `cfg_hi_enable`=1, `wr_n` pulses on every write.
- R8: On an 8-bit bus a word request runs two byte cycles, first at the even address and then at that address+1. `hi_n` stays high throughout, and `wr_n` pulses in every write cycle.
- R9: Write data is placed as follows. A 16-bit word goes out as is. A byte is replicated on both halves of `ad_out`, and on an 8-bit bus the current byte sits in [7:0]. Read data is returned as follows. A byte comes back in `rdata[7:0]` with zeros above it, taken from `ad_in[15:8]` for an odd address on a 16-bit bus and from `ad_in[7:0]` otherwise. A word comes back as {high byte, low byte}.
- R10: `clk_out` toggles on every clock edge, which gives half the clock frequency at 50% duty cycle. It is low in reset.
- R11: A request is accepted only while `busy` is low, and `busy` is high from the next cycle. `done` is a one-cycle pulse after the last bus cycle, with `busy` low and `rdata` valid. A request raised while busy is ignored.
- R12: In reset and when idle, `ale`=0, `rd_n`=`wr_n`=`hi_n`=1, `busy`=0 and `done`=0. In reset `ad_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bw_a | input | 1 | Bus width configuration bit a |
| cfg_bw_b | input | 1 | Bus width configuration bit b |
| cfg_hi_enable | input | 1 | 1: `hi_n` is a high-byte enable; 0: high-byte write strobe |
| bus_wide_in | input | 1 | External width input (1 = 16-bit) |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | BUS_W | Byte address |
| req_wdata | input | BUS_W | Write data |
| busy | output | 1 | Sequencer occupied |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | BUS_W | Read data |
| ad_out | output | BUS_W | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | BUS_W | Multiplexed bus data in |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write / low-byte write strobe, active low |
| hi_n | output | 1 | High-byte enable or high-byte write strobe, active low |
| clk_out | output | 1 | Clock at half the core rate |

## Verification
The assertions check on every cycle that the latch strobe appears only inside a busy cycle, only with the bus driven, and only as a two-cycle pulse. They also check that read and write strobes never overlap each other or the latch strobe, that `hi_n` stays high on a narrow bus, that `clk_out` toggles on every edge, and that `done` is a single cycle with the sequencer idle. Only the bench scenarios can show the cycle count chosen for each width setting, the address issued for each byte cycle, which byte lanes a write actually reaches, and the assembled read data. The bench sweeps every combination of configuration, direction, size and address parity for this.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SYNC = 3'd1,
    ST_T1   = 3'd2,
    ST_T2   = 3'd3,
    ST_T3   = 3'd4
  } ebs_state_e;

  function automatic logic wide_bus(input logic a, input logic b, input logic pin);
    // (0,x): 8-bit, (1,0): 16-bit, (1,1): pin decides
    return a & (~b | pin);
  endfunction
endpackage

// File: rtl/ebs_clkdiv.sv
module ebs_clkdiv (
  input  logic clk,
  input  logic rst_n,
  output logic ph
);
  logic ph_q;
  logic ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign ph = ph_q;
endmodule

// File: rtl/ebs_width.sv
module ebs_width (
  input  logic cfg_a,
  input  logic cfg_b,
  input  logic pin,
  output logic wide
);
  import ebs_pkg::*;
  always_comb wide = wide_bus(cfg_a, cfg_b, pin);
endmodule

// File: rtl/ebs_seq.sv
module ebs_seq #(
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [BUS_W-1:0]  req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic              wide_in,
  input  logic [BUS_W-1:0]  ad_in,
  output ebs_pkg::ebs_state_e state,
  output logic              busy,
  output logic              done,
  output logic [BUS_W-1:0]  rdata,
  output logic [BUS_W-1:0]  addr_cur,
  output logic [BUS_W-1:0]  wdata,
  output logic              write,
  output logic              word,
  output logic              wide,
  output logic              second
);
  import ebs_pkg::*;
  localparam int BYTE_W = BUS_W / 2;

  ebs_state_e       st_q, st_d;
  logic             wr_q, wr_d, wd_q, wd_d, wide_q, wide_d, sec_q, sec_d, done_q, done_d;
  logic [BUS_W-1:0] addr_q, addr_d, wdat_q, wdat_d, rdat_q, rdat_d;
  logic             accept, adv, split, last_cyc, a0;

  always_comb begin
    accept   = (st_q == ST_IDLE) && req_valid;
    adv      = ph;
    split    = wd_q && !wide_q;
    last_cyc = !(split && !sec_q);
    a0       = addr_q[0] | sec_q;
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    wr_d   = wr_q;
    wd_d   = wd_q;
    wide_d = wide_q;
    sec_d  = sec_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    rdat_d = rdat_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d   = ph ? ST_T1 : ST_SYNC;
        wr_d   = req_write;
        wd_d   = req_word;
        wide_d = wide_in;
        sec_d  = 1'b0;
        addr_d = req_word ? {req_addr[BUS_W-1:1], 1'b0} : req_addr;
        wdat_d = req_wdata;
        rdat_d = '0;
      end
      ST_SYNC: if (adv) st_d = ST_T1;
      ST_T1:   if (adv) st_d = ST_T2;
      ST_T2:   if (adv) begin
        st_d = ST_T3;
        if (!wr_q) begin
          if (wide_q) begin
            if (wd_q)    rdat_d = ad_in;
            else if (a0) rdat_d = {{BYTE_W{1'b0}}, ad_in[BUS_W-1:BYTE_W]};
            else         rdat_d = {{BYTE_W{1'b0}}, ad_in[BYTE_W-1:0]};
          end else if (sec_q) begin
            rdat_d = {ad_in[BYTE_W-1:0], rdat_q[BYTE_W-1:0]};
          end else begin
            rdat_d = {rdat_q[BUS_W-1:BYTE_W], ad_in[BYTE_W-1:0]};
          end
        end
      end
      ST_T3:   if (adv) begin
        if (last_cyc) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d  = ST_T1;
          sec_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wr_q   <= 1'b0;
      wd_q   <= 1'b0;
      wide_q <= 1'b0;
      sec_q  <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      st_q   <= st_d;
      wr_q   <= wr_d;
      wd_q   <= wd_d;
      wide_q <= wide_d;
      sec_q  <= sec_d;
      done_q <= done_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
    end
  end

  assign state    = st_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign rdata    = rdat_q;
  assign addr_cur = {addr_q[BUS_W-1:1], a0};
  assign wdata    = wdat_q;
  assign write    = wr_q;
  assign word     = wd_q;
  assign wide     = wide_q;
  assign second   = sec_q;
endmodule

// File: rtl/ebs_lanes.sv
module ebs_lanes #(
  parameter int BUS_W = 16
) (
  input  ebs_pkg::ebs_state_e state,
  input  logic              wide,
  input  logic              hi_enable,
  input  logic              write,
  input  logic              word,
  input  logic              second,
  input  logic [BUS_W-1:0]  addr_cur,
  input  logic [BUS_W-1:0]  wdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              hi_n,
  output logic              ad_oe,
  output logic [BUS_W-1:0]  ad_out
);
  import ebs_pkg::*;
  localparam int BYTE_W = BUS_W / 2;

  logic t1, t2, t3, in_cyc, touch_hi, touch_lo;
  logic [BYTE_W-1:0] cur_byte;

  always_comb begin
    t1       = (state == ST_T1);
    t2       = (state == ST_T2);
    t3       = (state == ST_T3);
    in_cyc   = t1 | t2 | t3;
    touch_hi = wide & (word | addr_cur[0]);
    touch_lo = ~wide | word | ~addr_cur[0];
    cur_byte = second ? wdata[BUS_W-1:BYTE_W] : wdata[BYTE_W-1:0];

    ale   = t1;
    rd_n  = ~(t2 & ~write);
    wr_n  = ~(t2 & write & (hi_enable | touch_lo));
    if (!wide)          hi_n = 1'b1;
    else if (hi_enable) hi_n = ~(in_cyc & touch_hi);
    else                hi_n = ~(t2 & write & touch_hi);

    ad_oe = t1 | (write & (t2 | t3));
    if (t1)                ad_out = addr_cur;
    else if (wide && word) ad_out = wdata;
    else                   ad_out = {cur_byte, cur_byte};
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_bw_a,
  input  logic             cfg_bw_b,
  input  logic             cfg_hi_enable,
  input  logic             bus_wide_in,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_word,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             busy,
  output logic             done,
  output logic [BUS_W-1:0] rdata,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  input  logic [BUS_W-1:0] ad_in,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             hi_n,
  output logic             clk_out
);
  import ebs_pkg::*;

  logic             ph, wide_now, wide_lat, wr_lat, wd_lat, sec_lat;
  ebs_state_e       state;
  logic [BUS_W-1:0] addr_cur, wdat_lat;

  ebs_clkdiv u_clkdiv (.clk(clk), .rst_n(rst_n), .ph(ph));

  ebs_width u_width (
    .cfg_a(cfg_bw_a), .cfg_b(cfg_bw_b), .pin(bus_wide_in), .wide(wide_now)
  );

  ebs_seq #(.BUS_W(BUS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ph(ph),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .wide_in(wide_now),
    .ad_in(ad_in), .state(state), .busy(busy), .done(done), .rdata(rdata),
    .addr_cur(addr_cur), .wdata(wdat_lat), .write(wr_lat), .word(wd_lat),
    .wide(wide_lat), .second(sec_lat)
  );

  ebs_lanes #(.BUS_W(BUS_W)) u_lanes (
    .state(state), .wide(wide_lat), .hi_enable(cfg_hi_enable),
    .write(wr_lat), .word(wd_lat), .second(sec_lat),
    .addr_cur(addr_cur), .wdata(wdat_lat),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .hi_n(hi_n),
    .ad_oe(ad_oe), .ad_out(ad_out)
  );

  assign clk_out = ph;
endmodule

// File: rtl/ebs_checker.sv
module ebs_checker (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic hi_n,
  input logic ad_oe,
  input logic busy,
  input logic done,
  input logic clk_out,
  input logic wide_lat
);
  assert_ale_in_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> busy);
  assert_ale_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe);
  assert_ale_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);
  assert_ale_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && $past(ale)) |=> !ale);
  assert_no_strobe_in_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));
  assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_narrow_hi_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wide_lat) |-> hi_n);
  assert_clk_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (clk_out != $past(clk_out)));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_n && wr_n && hi_n && !ale));
endmodule

bind ext_bus_seq ebs_checker u_ebs_checker (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .hi_n(hi_n), .ad_oe(ad_oe), .busy(busy), .done(done),
  .clk_out(clk_out), .wide_lat(wide_lat)
);

// File: tb/ext_bus_seq_bench.sv
module ext_bus_seq_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_a = 1'b0, cfg_b = 1'b0, cfg_hi = 1'b1, pin = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [W-1:0] req_addr = '0, req_wdata = '0;
  logic busy, done, ad_oe, ale, rd_n, wr_n, hi_n, clk_out;
  logic [W-1:0] rdata, ad_out, ad_in;

  always #10 clk = ~clk;

  ext_bus_seq #(.BUS_W(W)) u_ext_bus_seq (
    .clk(clk), .rst_n(rst_n), .cfg_bw_a(cfg_a), .cfg_bw_b(cfg_b),
    .cfg_hi_enable(cfg_hi), .bus_wide_in(pin), .req_valid(req_valid),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .hi_n(hi_n), .clk_out(clk_out)
  );

  int total = 0, bad = 0;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [W-1:0] lat = '0, first_lat = '0, last_lat = '0;
  logic w16_cfg = 1'b0, ale_prev = 1'b0, co_prev = 1'b0;
  int ale_cnt, ale_rises, rd_cnt, wr_cnt, hi_cnt, busy_cnt, done_cnt, co_bad, co_samples;

  assign ad_in = {mem[{lat[7:1], 1'b1}], mem[w16_cfg ? {lat[7:1], 1'b0} : lat[7:0]]};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus monitor and memory model
  always @(negedge clk) begin
    if (rst_n) begin
      if (ale) begin
        if (!ale_prev) begin
          ale_rises++;
          if (ale_rises == 1) first_lat = ad_out;
          last_lat = ad_out;
        end
        lat = ad_out;
        ale_cnt++;
      end
      ale_prev = ale;
      if (clk_out == co_prev) co_bad++;
      co_prev = clk_out;
      co_samples++;
      if (!rd_n) rd_cnt++;
      if (!wr_n) wr_cnt++;
      if (!hi_n) hi_cnt++;
      if (busy) busy_cnt++;
      if (done) done_cnt++;
      if (!w16_cfg) begin
        if (!wr_n) mem[lat[7:0]] = ad_out[7:0];
      end else if (cfg_hi) begin
        if (!wr_n) begin
          if (!hi_n)  mem[{lat[7:1], 1'b1}] = ad_out[15:8];
          if (!lat[0]) mem[{lat[7:1], 1'b0}] = ad_out[7:0];
        end
      end else begin
        if (!wr_n) mem[{lat[7:1], 1'b0}] = ad_out[7:0];
        if (!hi_n) mem[{lat[7:1], 1'b1}] = ad_out[15:8];
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic run_txn(input bit wr, input bit wd, input logic [W-1:0] addr,
                         input logic [W-1:0] wdat);
    logic [W-1:0] ea;
    logic [7:0] lo_i, hi_i;
    int ncyc, exp_hi, exp_wr;
    bit th, tl, fixed;
    string rq;
    ea    = wd ? {addr[W-1:1], 1'b0} : addr;
    ncyc  = (wd && !w16_cfg) ? 2 : 1;
    th    = wd || addr[0];
    tl    = wd || !addr[0];
    fixed = (cfg_a != cfg_b);
    if (!w16_cfg)    exp_hi = 0;
    else if (cfg_hi) exp_hi = th ? 6 : 0;
    else             exp_hi = (wr && th) ? 2 : 0;
    if (!wr)                     exp_wr = 0;
    else if (!w16_cfg || cfg_hi) exp_wr = 2 * ncyc;
    else                         exp_wr = tl ? 2 : 0;

    tick();
    ale_cnt = 0; ale_rises = 0; rd_cnt = 0; wr_cnt = 0; hi_cnt = 0;
    busy_cnt = 0; done_cnt = 0;
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = addr; req_wdata = wdat;
    tick();
    chk(busy === 1'b1, "R11", "busy after accept", busy, 1);
    // stray request while busy: must be ignored
    req_addr = addr ^ 16'h0040; req_write = ~wr;
    tick();
    req_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done_cnt != 0) break;
      tick();
    end
    if (!wr) begin
      lo_i = wd ? {ea[7:1], 1'b0} : ea[7:0];
      hi_i = {ea[7:1], 1'b1};
      chk(rdata === (wd ? {exp_mem[hi_i], exp_mem[lo_i]} : {8'h00, exp_mem[ea[7:0]]}),
          "R9", "read data", rdata,
          wd ? {exp_mem[hi_i], exp_mem[lo_i]} : {8'h00, exp_mem[ea[7:0]]});
    end
    chk(busy_cnt == 6*ncyc || busy_cnt == 6*ncyc + 1, "R11", "busy cycles", busy_cnt, 6*ncyc);
    tick();
    chk(done_cnt == 1 && busy == 1'b0, "R11", "single done, stray ignored", done_cnt, 1);
    chk(ale_cnt == 2*ncyc, "R1", "ale high cycles", ale_cnt, 2*ncyc);
    rq = fixed ? "R4" : "R3";
    chk(ale_rises == ncyc, rq, "bus cycles per request", ale_rises, ncyc);
    rq = (wd && addr[0] && w16_cfg) ? "R5" : "R1";
    chk(first_lat == ea, rq, "first address", first_lat, ea);
    if (ncyc == 2)
      chk(last_lat == ea + 16'd1, "R8", "second byte address", last_lat, ea + 16'd1);
    chk(rd_cnt == (wr ? 0 : 2*ncyc), "R2", "read strobe cycles", rd_cnt, wr ? 0 : 2*ncyc);
    chk(wr_cnt == exp_wr, cfg_hi ? "R7" : "R6", "wr_n cycles", wr_cnt, exp_wr);
    rq = !w16_cfg ? "R8" : (cfg_hi ? "R5" : "R6");
    chk(hi_cnt == exp_hi, rq, "hi_n cycles", hi_cnt, exp_hi);
    if (wr) begin
      if (wd) begin
        exp_mem[{ea[7:1], 1'b0}] = wdat[7:0];
        exp_mem[{ea[7:1], 1'b1}] = wdat[15:8];
      end else begin
        exp_mem[ea[7:0]] = wdat[7:0];
      end
      chk(mem[{ea[7:1], 1'b0}] == exp_mem[{ea[7:1], 1'b0}], "R9", "low byte in memory",
          mem[{ea[7:1], 1'b0}], exp_mem[{ea[7:1], 1'b0}]);
      chk(mem[{ea[7:1], 1'b1}] == exp_mem[{ea[7:1], 1'b1}], "R9", "high byte in memory",
          mem[{ea[7:1], 1'b1}], exp_mem[{ea[7:1], 1'b1}]);
    end
  endtask

  initial begin
    int k;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 11);
      exp_mem[i] = 8'(i * 37 + 11);
    end
    repeat (3) tick();
    // R12 reset state
    chk(ale === 1'b0 && rd_n === 1'b1 && wr_n === 1'b1 && hi_n === 1'b1, "R12",
        "strobes in reset", {ale, rd_n, wr_n, hi_n}, 4'b0111);
    chk(busy === 1'b0 && done === 1'b0 && ad_oe === 1'b0, "R12", "status in reset",
        {busy, done, ad_oe}, 0);
    chk(clk_out === 1'b0, "R10", "clk_out in reset", clk_out, 0);
    co_prev = 1'b0; co_bad = 0; co_samples = 0;
    rst_n = 1'b1;
    tick();
    k = 0;
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 2; p++)
          for (int h = 0; h < 2; h++)
            for (int wr = 0; wr < 2; wr++)
              for (int wd = 0; wd < 2; wd++)
                for (int l = 0; l < 2; l++) begin
                  cfg_a = a[0]; cfg_b = b[0]; pin = p[0]; cfg_hi = h[0];
                  w16_cfg = a[0] & (~b[0] | p[0]);
                  run_txn(wr[0], wd[0], 16'h5A00 | 16'((k * 6) & 8'hFE) | 16'(l),
                          16'hC35A ^ 16'(k * 16'h0111));
                  k++;
                end
    tick();
    chk(busy === 1'b0 && rd_n === 1'b1 && wr_n === 1'b1 && hi_n === 1'b1 && ale === 1'b0,
        "R12", "idle strobes", {busy, rd_n, wr_n, hi_n, ale}, 5'b01110);
    chk(co_bad == 0, "R10", "clk_out toggles every edge", co_bad, 0);
    chk(co_samples > 1000, "R10", "clk_out samples", co_samples, 1000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule